// File: doc/BRIEF.md
# Time-Based VGA Sync Generator

This block derives the horizontal and vertical timing of a fixed 640×480 display from a 100 MHz system clock. The horizontal axis is counted directly in system clock cycles. The line is 3177 cycles long, and the visible part at its start is stretched to 2560 cycles, which is 640 pixels of four clocks each. The vertical axis does not count lines. It counts whole microseconds, using a one-cycle enable that fires once every 100 clocks. The frame therefore lasts 16784 µs, whatever the line length is.

Downstream pixel logic uses the two sync levels and the two blank flags, which are active high and mean "drive black". It also uses two single-cycle markers: one at the head of every line, and one when a line head coincides with the first microsecond of a frame. Every output is registered, so all six move together, one clock after the counter state they encode.

Top module: `vga_time_sync`

## Requirements
- R1: While `rstN` is low, and immediately on its assertion, `hsync` and `vsync` are 1 and `hblank`, `vblank`, `lineStart` and `frameStart` are 0. After release, output cycle n (n = 0, 1, ...) reflects horizontal count n mod LINE_CYCLES and microsecond count floor(n / TICK_DIV) mod FRAME_TICKS.
- R2: `lineStart` is 1 for exactly one cycle whenever the horizontal count is 0, so once every LINE_CYCLES clocks.
- R3: `hblank` is 1 for horizontal counts ACTIVE_CYCLES through LINE_CYCLES-1 and 0 for counts 0 through ACTIVE_CYCLES-1.
- R4: `hsync` is 0 for horizontal counts HSYNC_FIRST through HSYNC_STOP-1 (2611 to 2987 by default) and 1 otherwise.
- R5: The microsecond count advances once every TICK_DIV clocks and wraps to 0 after FRAME_TICKS counts.
- R6: `vblank` is 1 for microsecond counts VACTIVE_TICKS through FRAME_TICKS-1 and 0 before that.
- R7: `vsync` is 0 for microsecond counts VSYNC_FIRST through VSYNC_STOP-1 (15700 to 15763 by default) and 1 otherwise.
- R8: `frameStart` is 1 for one cycle only when the horizontal count and the microsecond count are both 0. A frame whose first microsecond holds no line head produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz at default timing) |
| rstN | input | 1 | Asynchronous active-low reset |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| hblank | output | 1 | High while outside the horizontal visible window |
| vblank | output | 1 | High while outside the vertical visible window |
| lineStart | output | 1 | One-cycle marker at horizontal count 0 |
| frameStart | output | 1 | One-cycle marker when both counts are 0 |

## Verification
The hardest case to reach is the frame marker's dependence on the line and microsecond counts lining up. At default timing the two periods are coprime, so the pulse is missing from nearly every frame, and confirming that takes millions of cycles. The bench therefore shrinks every timing parameter to a line of 40 clocks and a frame of 300 clocks, so that a line head falls on the frame's first microsecond only every other frame. Both the pulsed and the silent frames are then compared cycle by cycle against closed-form expectations, and a mid-run reset shows that the phase restarts from zero.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;

  // Strobes passed from the timebase control to the output datapath.
  typedef struct packed {
    logic usTick;    // last clock of the current microsecond
    logic lineHead;  // horizontal count is zero this cycle
  } syncStrobes_t;

endpackage

// File: rtl/vga_sync_ctrl.sv
module vga_sync_ctrl
  import vga_sync_pkg::*;
#(
  parameter int LINE_CYCLES = 3177,
  parameter int TICK_DIV    = 100,
  localparam int HW = $clog2(LINE_CYCLES),
  localparam int TW = $clog2(TICK_DIV)
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [HW-1:0] hCount,
  output syncStrobes_t  strobes
);

  localparam logic [HW-1:0] H_LAST = HW'(LINE_CYCLES - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] tickCnt;

  // Microsecond prescaler: one enable per TICK_DIV clocks, no derived clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickCnt == T_LAST) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // Horizontal position in system clocks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
    end else if (hCount == H_LAST) begin
      hCount <= '0;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  always_comb begin
    strobes.usTick   = (tickCnt == T_LAST);
    strobes.lineHead = (hCount == '0);
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.usTick |=> !strobes.usTick);  // R5

endmodule

// File: rtl/vga_sync_datapath.sv
module vga_sync_datapath
  import vga_sync_pkg::*;
#(
  parameter int LINE_CYCLES   = 3177,
  parameter int ACTIVE_CYCLES = 2560,
  parameter int HSYNC_FIRST   = 2611,
  parameter int HSYNC_STOP    = 2988,
  parameter int FRAME_TICKS   = 16784,
  parameter int VACTIVE_TICKS = 15250,
  parameter int VSYNC_FIRST   = 15700,
  parameter int VSYNC_STOP    = 15764,
  localparam int HW = $clog2(LINE_CYCLES),
  localparam int VW = $clog2(FRAME_TICKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [HW-1:0] hCount,
  input  syncStrobes_t  strobes,
  output logic          hsync,
  output logic          vsync,
  output logic          hblank,
  output logic          vblank,
  output logic          lineStart,
  output logic          frameStart
);

  localparam logic [HW-1:0] H_ACT  = HW'(ACTIVE_CYCLES);
  localparam logic [HW-1:0] H_SYA  = HW'(HSYNC_FIRST);
  localparam logic [HW-1:0] H_SYB  = HW'(HSYNC_STOP);
  localparam logic [VW-1:0] V_LAST = VW'(FRAME_TICKS - 1);
  localparam logic [VW-1:0] V_ACT  = VW'(VACTIVE_TICKS);
  localparam logic [VW-1:0] V_SYA  = VW'(VSYNC_FIRST);
  localparam logic [VW-1:0] V_SYB  = VW'(VSYNC_STOP);

  logic [VW-1:0] vCount;

  // Frame position in microseconds.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vCount <= '0;
    end else if (strobes.usTick) begin
      if (vCount == V_LAST) vCount <= '0;
      else                  vCount <= vCount + 1'b1;
    end
  end

  // Registered decode keeps all six outputs on the same clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsync      <= 1'b1;
      vsync      <= 1'b1;
      hblank     <= 1'b0;
      vblank     <= 1'b0;
      lineStart  <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      hsync      <= !((hCount >= H_SYA) && (hCount < H_SYB));
      hblank     <= (hCount >= H_ACT);
      vsync      <= !((vCount >= V_SYA) && (vCount < V_SYB));
      vblank     <= (vCount >= V_ACT);
      lineStart  <= strobes.lineHead;
      frameStart <= strobes.lineHead && (vCount == '0);
    end
  end

  AST_VCOUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.usTick |=> $stable(vCount));  // R5
  AST_LINE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !lineStart);  // R2
  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> lineStart);  // R8
  AST_HSYNC_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !hsync |-> hblank);  // R4
  AST_VSYNC_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |-> vblank);  // R7

endmodule

// File: rtl/vga_time_sync.sv
module vga_time_sync
  import vga_sync_pkg::*;
#(
  parameter int LINE_CYCLES   = 3177,
  parameter int ACTIVE_CYCLES = 2560,
  parameter int HSYNC_FIRST   = 2611,
  parameter int HSYNC_STOP    = 2988,
  parameter int TICK_DIV      = 100,
  parameter int FRAME_TICKS   = 16784,
  parameter int VACTIVE_TICKS = 15250,
  parameter int VSYNC_FIRST   = 15700,
  parameter int VSYNC_STOP    = 15764
) (
  input  logic clk,
  input  logic rstN,
  output logic hsync,
  output logic vsync,
  output logic hblank,
  output logic vblank,
  output logic lineStart,
  output logic frameStart
);

  localparam int HW = $clog2(LINE_CYCLES);

  logic [HW-1:0] hCount;
  syncStrobes_t  strobes;

  vga_sync_ctrl #(
    .LINE_CYCLES(LINE_CYCLES),
    .TICK_DIV   (TICK_DIV)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hCount (hCount),
    .strobes(strobes)
  );

  vga_sync_datapath #(
    .LINE_CYCLES  (LINE_CYCLES),
    .ACTIVE_CYCLES(ACTIVE_CYCLES),
    .HSYNC_FIRST  (HSYNC_FIRST),
    .HSYNC_STOP   (HSYNC_STOP),
    .FRAME_TICKS  (FRAME_TICKS),
    .VACTIVE_TICKS(VACTIVE_TICKS),
    .VSYNC_FIRST  (VSYNC_FIRST),
    .VSYNC_STOP   (VSYNC_STOP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hCount    (hCount),
    .strobes   (strobes),
    .hsync     (hsync),
    .vsync     (vsync),
    .hblank    (hblank),
    .vblank    (vblank),
    .lineStart (lineStart),
    .frameStart(frameStart)
  );

endmodule

// File: tb/vga_time_sync_bench.sv
module vga_time_sync_bench;

  localparam int CLK_PERIOD = 10;
  localparam int L_CYC  = 40;
  localparam int H_ACT  = 24;
  localparam int HS_A   = 28;
  localparam int HS_B   = 33;
  localparam int T_DIV  = 5;
  localparam int F_TCK  = 60;
  localparam int V_ACT  = 40;
  localparam int VS_A   = 45;
  localparam int VS_B   = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsync, vsync, hblank, vblank, lineStart, frameStart;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int framePulses = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vga_time_sync #(
    .LINE_CYCLES(L_CYC), .ACTIVE_CYCLES(H_ACT),
    .HSYNC_FIRST(HS_A), .HSYNC_STOP(HS_B),
    .TICK_DIV(T_DIV), .FRAME_TICKS(F_TCK),
    .VACTIVE_TICKS(V_ACT), .VSYNC_FIRST(VS_A), .VSYNC_STOP(VS_B)
  ) u_vga_time_sync (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync),
    .hblank(hblank), .vblank(vblank),
    .lineStart(lineStart), .frameStart(frameStart)
  );

  // Number of clock edges seen out of reset.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) edges <= 0;
    else       edges <= edges + 1;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s edge=%0d actual=%b expected=%b", req, what, edges, act, exp);
    end
  endtask

  task automatic chkResetState(input string tag);
    chk("R1", {tag, " hsync"}, hsync, 1'b1);
    chk("R1", {tag, " vsync"}, vsync, 1'b1);
    chk("R1", {tag, " hblank"}, hblank, 1'b0);
    chk("R1", {tag, " vblank"}, vblank, 1'b0);
    chk("R1", {tag, " lineStart"}, lineStart, 1'b0);
    chk("R1", {tag, " frameStart"}, frameStart, 1'b0);
  endtask

  // Reference: closed form in the edge index n.
  task automatic chkCycle();
    int n, h, t;
    n = edges - 1;
    h = n % L_CYC;
    t = (n / T_DIV) % F_TCK;
    chk("R2", "lineStart", lineStart, h == 0);
    chk("R3", "hblank", hblank, h >= H_ACT);
    chk("R4", "hsync", hsync, !(h >= HS_A && h < HS_B));
    chk("R6", "vblank", vblank, t >= V_ACT);
    chk("R7", "vsync", vsync, !(t >= VS_A && t < VS_B));
    chk("R8", "frameStart", frameStart, (h == 0) && (t == 0));
    if (frameStart) framePulses++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chkResetState("held");
    rstN = 1'b1;
    // Four frames of 300 clocks: markers at edges 0, 600 and 1200 only (R8, R5 wrap).
    for (int i = 0; i < 1230; i++) begin
      @(negedge clk);
      chkCycle();
    end
    chk("R8", "frame pulses over 1230 edges", framePulses == 3, 1'b1);
    // Mid-frame asynchronous reset.
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chkResetState("async");
    repeat (2) @(negedge clk);
    chkResetState("held2");
    rstN = 1'b1;
    framePulses = 0;
    for (int i = 0; i < 650; i++) begin
      @(negedge clk);
      chkCycle();
    end
    chk("R1", "phase restart pulses", framePulses == 2, 1'b1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule